// File: doc/BRIEF.md
# Side-Set and Delay Field Decoder

This block sits beside an instruction sequencer and deals with one five-bit field carried in bits 12:8 of each 16-bit instruction word. At runtime that field is shared between two jobs: driving a small group of neighbouring pins on the same cycle as the instruction, and making the sequencer wait for some cycles after the instruction. A configured side-set pin count says how many of the field's upper bits are pin data. An optional-mode flag gives up one more bit as a per-instruction enable. The bits left over at the low end form the delay count.

A configured base index places the pin group anywhere in a 32-pin space, and the group wraps past pin 31. A direction-mode flag chooses whether the side-set bits set output levels or output enables. The block accepts an instruction when `instrValid` is high and `stall` is low. It updates the pin vectors at that clock edge. It then holds `stall` high for exactly the decoded number of cycles, and the sequencer must not issue while `stall` is high.

Top module: `sideset_delay_unit`

## Requirements
- R1: While `rstN` is low, `gpioOut` and `gpioDir` are all zeros and `stall` is low.
- R2: The field is instruction bits 12:8, called f[4:0]. With optional mode off and an effective count c, the side-set value is f[4:5-c] and the delay is the low 5-c bits of f.
- R3: With optional mode on, f[4] is an enable. The effective count is limited to at most 4. The side-set value is f[3:4-c] and the delay is the low 4-c bits of f. When f[4] is 0, no pin changes, but the delay still applies.
- R4: Bit i of the side-set value drives pin (base + i) mod 32, for i below c. All other pins keep their values.
- R5: When the direction mode is 0, only `gpioOut` is updated. When it is 1, only `gpioDir` is updated.
- R6: The pin change shows in the cycle right after the accepting edge. No extra cycle is inserted, whatever the delay.
- R7: A delay of N makes `stall` high for exactly the N cycles after the instruction cycle. A delay of 0 gives no stall.
- R8: A count of 0 with optional mode off makes all five bits delay and drives no pins. Count values above 5 act as 5.
- R9: While `stall` is high, `instrValid` is ignored. No pin changes and the delay is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSideCount | input | 3 | Side-set pin count (0..5; larger values act as 5) |
| cfgOptional | input | 1 | Optional mode: the field MSB is a side-set enable |
| cfgBase | input | 5 | Index of the pin driven by side-set bit 0 |
| cfgPinDir | input | 1 | 0: drive output levels, 1: drive output enables |
| instrValid | input | 1 | An instruction is offered this cycle |
| instrWord | input | 16 | Instruction word; bits 12:8 are decoded |
| gpioOut | output | 32 | Registered output level vector |
| gpioDir | output | 32 | Registered output enable vector |
| stall | output | 1 | High while a delay is in progress; issue is blocked |

## Verification
Random instruction words are driven with random counts (including 6 and 7), with both optional-mode settings, random base values, and both direction modes. This shows whether the field is split at the right bit for every count, and whether bits land on the correct wrapped pin. Directed cases cover count 0 with the full 31-cycle delay, optional mode with the enable clear, and a base of 30 with five pins. The last case separates modulo wrapping from plain truncation. Issue attempts made during a stall test whether a busy unit is truly deaf to input: the pins must stay unchanged and the stall length must stay unchanged.

// File: rtl/sideset_pkg.sv
package sideset_pkg;
  localparam int FIELD_W  = 5;
  localparam int FIELD_LO = 8;
  localparam int PIN_W    = 32;
  localparam int IDX_W    = $clog2(PIN_W);
  localparam int CNT_W    = 3;

  typedef struct packed {
    logic accept;     // instruction taken at this edge
    logic loadDelay;  // load the delay counter
  } ctrlStrobes_t;
endpackage

// File: rtl/sideset_datapath.sv
module sideset_datapath
  import sideset_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     cfgSideCount,
  input  logic                 cfgOptional,
  input  logic [IDX_W-1:0]     cfgBase,
  input  logic                 cfgPinDir,
  input  logic [15:0]          instrWord,
  input  ctrlStrobes_t         strobes,
  output logic [FIELD_W-1:0]   delayOut,
  output logic [PIN_W-1:0]     gpioOut,
  output logic [PIN_W-1:0]     gpioDir
);
  logic [FIELD_W-1:0] field;
  logic [CNT_W-1:0]   effCount;
  logic               sideEn;
  logic [FIELD_W-1:0] sideVal;
  logic [PIN_W-1:0]   pinMask;
  logic [PIN_W-1:0]   pinVal;

  assign field = instrWord[FIELD_LO +: FIELD_W];

  // limit the count to the field width, minus the enable bit when optional
  always_comb begin
    effCount = (cfgSideCount > CNT_W'(FIELD_W)) ? CNT_W'(FIELD_W) : cfgSideCount;
    if (cfgOptional && (effCount > CNT_W'(FIELD_W - 1)))
      effCount = CNT_W'(FIELD_W - 1);
  end

  // split the field: side bits from the top, delay bits from the bottom
  always_comb begin
    logic [FIELD_W-1:0] body;
    logic [CNT_W:0]     bodyW;
    body  = cfgOptional ? {1'b0, field[FIELD_W-2:0]} : field;
    bodyW = cfgOptional ? (CNT_W+1)'(FIELD_W - 1) : (CNT_W+1)'(FIELD_W);
    sideEn   = cfgOptional ? field[FIELD_W-1] : 1'b1;
    sideVal  = body >> (bodyW - (CNT_W+1)'(effCount));
    delayOut = body & ((FIELD_W'(1) << (bodyW - (CNT_W+1)'(effCount))) - FIELD_W'(1));
  end

  // scatter side bits onto consecutive pins, wrapping at PIN_W
  always_comb begin
    pinMask = '0;
    pinVal  = '0;
    for (int i = 0; i < FIELD_W; i++) begin
      logic [IDX_W-1:0] idx;
      idx = cfgBase + IDX_W'(i);
      if (sideEn && (CNT_W'(i) < effCount)) begin
        pinMask[idx] = 1'b1;
        pinVal[idx]  = sideVal[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpioOut <= '0;
      gpioDir <= '0;
    end else if (strobes.accept) begin
      if (cfgPinDir) gpioDir <= (gpioDir & ~pinMask) | pinVal;
      else           gpioOut <= (gpioOut & ~pinMask) | pinVal;
    end
  end
endmodule

// File: rtl/sideset_ctrl.sv
module sideset_ctrl
  import sideset_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [FIELD_W-1:0] delayIn,
  output ctrlStrobes_t       strobes,
  output logic               stall
);
  logic [FIELD_W-1:0] waitLeft;

  assign stall             = (waitLeft != '0);
  assign strobes.accept    = instrValid && !stall;
  assign strobes.loadDelay = strobes.accept;

  always_ff @(posedge clk) begin
    if (!rstN)                  waitLeft <= '0;
    else if (strobes.loadDelay) waitLeft <= delayIn;
    else if (stall)             waitLeft <= waitLeft - FIELD_W'(1);
  end
endmodule

// File: rtl/sideset_delay_unit.sv
module sideset_delay_unit
  import sideset_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cfgSideCount,
  input  logic        cfgOptional,
  input  logic [4:0]  cfgBase,
  input  logic        cfgPinDir,
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  output logic [31:0] gpioOut,
  output logic [31:0] gpioDir,
  output logic        stall
);
  ctrlStrobes_t       strobes;
  logic [FIELD_W-1:0] delayVal;

  sideset_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .delayIn(delayVal), .strobes(strobes), .stall(stall)
  );

  sideset_datapath i_dp (
    .clk(clk), .rstN(rstN), .cfgSideCount(cfgSideCount),
    .cfgOptional(cfgOptional), .cfgBase(cfgBase), .cfgPinDir(cfgPinDir),
    .instrWord(instrWord), .strobes(strobes), .delayOut(delayVal),
    .gpioOut(gpioOut), .gpioDir(gpioDir)
  );
endmodule

// File: rtl/sideset_delay_unit_chk.sv
module sideset_delay_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  cfgSideCount,
  input logic        cfgOptional,
  input logic        cfgPinDir,
  input logic        instrValid,
  input logic [15:0] instrWord,
  input logic [31:0] gpioOut,
  input logic [31:0] gpioDir,
  input logic        stall
);
  // R9
  busy_ignores_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(gpioOut) && $stable(gpioDir)));
  // R7
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !instrValid) |=> !stall);
  // R5
  dir_mode_keeps_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgPinDir |=> $stable(gpioOut));
  // R5
  val_mode_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgPinDir |=> $stable(gpioDir));
  // R8
  zero_count_no_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSideCount == 3'd0 && !cfgOptional) |=> ($stable(gpioOut) && $stable(gpioDir)));
  // R3
  opt_disabled_no_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOptional && !instrWord[12]) |=> ($stable(gpioOut) && $stable(gpioDir)));
endmodule

bind sideset_delay_unit sideset_delay_unit_chk i_chk (
  .clk(clk), .rstN(rstN), .cfgSideCount(cfgSideCount), .cfgOptional(cfgOptional),
  .cfgPinDir(cfgPinDir), .instrValid(instrValid), .instrWord(instrWord),
  .gpioOut(gpioOut), .gpioDir(gpioDir), .stall(stall)
);

// File: tb/test_sideset_delay_unit.sv
module test_sideset_delay_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic [2:0]  cfgSideCount = 0;
  logic        cfgOptional = 0;
  logic [4:0]  cfgBase = 0;
  logic        cfgPinDir = 0;
  logic        instrValid = 0;
  logic [15:0] instrWord = 0;
  logic [31:0] gpioOut, gpioDir;
  logic        stall;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expOut = 0, expDir = 0;
  logic [31:0] mMask, mVal;
  int          mDelay;

  always #2.5 clk = ~clk;

  sideset_delay_unit i_sideset_delay_unit (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference split of the field (R2, R3, R4, R8)
  task automatic model(input int cnt, input bit opt, input int base, input logic [15:0] w);
    int eff, bw;
    bit en;
    logic [4:0] f, body, side;
    f = w[12:8];
    eff = (cnt > 5) ? 5 : cnt;
    if (opt && eff > 4) eff = 4;
    bw   = opt ? 4 : 5;
    body = opt ? {1'b0, f[3:0]} : f;
    en   = opt ? f[4] : 1'b1;
    side = body >> (bw - eff);
    mDelay = int'(body) & ((1 << (bw - eff)) - 1);
    mMask = 0; mVal = 0;
    if (en)
      for (int i = 0; i < eff; i++) begin
        mMask[(base + i) % 32] = 1'b1;
        mVal[(base + i) % 32]  = side[i];
      end
  endtask

  task automatic run(input int cnt, input bit opt, input int base, input bit dir,
                     input logic [15:0] w, input bit inject, input string req);
    int n;
    @(negedge clk);
    cfgSideCount = 3'(cnt); cfgOptional = opt; cfgBase = 5'(base); cfgPinDir = dir;
    instrWord = w; instrValid = 1;
    model(cnt, opt, base, w);
    if (dir) expDir = (expDir & ~mMask) | mVal;
    else     expOut = (expOut & ~mMask) | mVal;
    @(negedge clk);
    instrValid = 0;
    // R6: pins visible in the cycle after the issue edge
    check({req, " R6 out"}, gpioOut, expOut);
    check({req, " R6 dir"}, gpioDir, expDir);
    n = 0;
    while (stall && n < 40) begin
      if (inject && n == 0) begin
        instrWord = ~w; instrValid = 1;   // R9: offered while busy
      end
      n++;
      @(negedge clk);
      instrValid = 0;
    end
    // R7 stall length
    check({req, " R7 stall"}, 32'(n), 32'(mDelay));
    if (inject) begin
      check("R9 out", gpioOut, expOut);
      check("R9 dir", gpioDir, expDir);
    end
  endtask

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1
    check("R1 out", gpioOut, 32'h0);
    check("R1 dir", gpioDir, 32'h0);
    check("R1 stall", 32'(stall), 32'h0);
    rstN = 1;
    // R8: count 0, full 31-cycle delay, no pins
    run(0, 0, 3, 0, 16'h1F00, 1, "R8");
    // R2: count 3, field 10110 -> side 101, delay 2
    run(3, 0, 4, 0, 16'h1600, 0, "R2");
    // R4: wrap past pin 31
    run(5, 0, 30, 0, 16'h1F00, 0, "R4");
    // R5: direction mode
    run(2, 0, 7, 1, 16'h1800, 0, "R5");
    // R3: optional, enable clear, delay still applies
    run(4, 1, 0, 0, 16'h0700, 0, "R3");
    // R3: optional with count 5 limited to 4
    run(5, 1, 10, 1, 16'h1F00, 1, "R3");
    // R8: count 7 acts as 5
    run(7, 0, 20, 0, 16'h1500, 0, "R8");
    for (int k = 0; k < 300; k++) begin
      run(int'($urandom_range(0, 7)), 1'($urandom), int'($urandom_range(0, 31)),
          1'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0), "R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #150000;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule